// File: doc/BRIEF.md
# Instruction-Cache Control and Line-Flush Register Block

This block is the software-facing configuration front of an instruction cache. It presents four 16-bit registers on a simple synchronous register bus. The first is a command register. Two registers together hold a 24-bit byte address for a line flush. The last is a 16-bit counter of tag mis-compares. Only two fixed command values are accepted. One starts a cache initialisation. The other flushes the single line selected by the flush address.

A flush does not touch the cache array directly. The block splits the stored byte address into a set index and a tag, using the same split a fetch uses. It then raises an invalidate request toward the cache core and holds it until the core acknowledges. The core invalidates the way whose tag matches, and only if that line is valid. The miss counter advances on a one-cycle event from the core, and software may read it or load it at any time.

Commands are only taken while the cache is disabled and no flush is outstanding. Any rejected command leaves the register state untouched and sets a sticky error flag, which only reset clears.

Top module: `cc_ctrl_regs`

## Requirements
- R1: After reset, all four registers read 0x0000, and `inv_req`, `init_pulse` and `cfg_err` are low.
- R2: Register selects are 0 = command, 1 = flush address low, 2 = flush address high, 3 = miss counter. The low register stores all 16 bits, which form address bits 15:0. The high register stores only written bits 7:0, which form address bits 23:16, and its bits 15:8 always read 0.
- R3: Writing 0xCE3C to the command register while `cache_en` is low and no flush is pending drives `init_pulse` high for exactly the one cycle after the write edge.
- R4: Writing 0xDE3C under the same conditions raises `inv_req` in the cycle after the write edge. At that point `inv_set` carries flush address bits 11:4 and `inv_tag` carries bits 23:12. Bits 3:0 select a byte within the 16-byte line and are dropped.
- R5: `inv_req` and its set and tag stay constant until `inv_ack` is sampled high. `inv_req` is low in the cycle after that edge.
- R6: A command-register write of any value other than 0xCE3C or 0xDE3C is ignored: there is no pulse, no request, and the readback is unchanged. It also sets `cfg_err`, which stays high until reset.
- R7: A command-register write while `cache_en` is high is ignored and sets `cfg_err`.
- R8: Each cycle with `miss_evt` high adds one to the miss counter, which wraps from 0xFFFF to 0x0000.
- R9: A software write to the miss counter in the same cycle as `miss_evt` loads the written value, and the event is lost.
- R10: A command-register write while a flush is pending (`inv_req` high) is ignored and sets `cfg_err`.
- R11: The command register reads back the last accepted command value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| cache_en | input | 1 | Cache enable state; commands are rejected while high |
| miss_evt | input | 1 | One tag mis-compare this cycle |
| init_pulse | output | 1 | One-cycle cache initialise command |
| inv_req | output | 1 | Line invalidate request |
| inv_set | output | 8 | Set index of the line to invalidate |
| inv_tag | output | 12 | Tag of the line to invalidate |
| inv_ack | input | 1 | Invalidate completed by the cache core |
| cfg_err | output | 1 | Sticky rejected-command flag |

## Verification
A corrupted flush-address register shows on `inv_set` and `inv_tag` in the first cycle of the next flush request. A stuck invalidate state machine shows as `inv_req` failing to fall one cycle after the acknowledge. A wrong acceptance decision shows within one cycle of the write, as an unexpected `init_pulse` or `inv_req`, a missing one, or an unchanged `cfg_err`. It also shows at once in the command readback. Counter faults appear on the first read after the events.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned CC_DATA_W = 16;
  localparam int unsigned CC_ADDR_W = 24;
  localparam int unsigned CC_OFFS_W = 4;
  localparam int unsigned CC_SET_W  = 8;
  localparam int unsigned CC_CNT_W  = 16;
  localparam logic [15:0] CC_CMD_INIT  = 16'hCE3C;
  localparam logic [15:0] CC_CMD_FLUSH = 16'hDE3C;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_FLO  = 2'd1,
    SEL_FHI  = 2'd2,
    SEL_MISS = 2'd3
  } reg_sel_e;

  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_WAIT = 1'b1
  } flush_st_e;
endpackage

// File: rtl/cc_cmd_decode.sv
module cc_cmd_decode #(
  parameter int unsigned DATA_W = cc_pkg::CC_DATA_W,
  parameter logic [DATA_W-1:0] INIT_CODE  = cc_pkg::CC_CMD_INIT,
  parameter logic [DATA_W-1:0] FLUSH_CODE = cc_pkg::CC_CMD_FLUSH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cache_en,
  input  logic              flush_busy,
  output logic [DATA_W-1:0] cmd_q,
  output logic              init_pulse,
  output logic              flush_go,
  output logic              cmd_take,
  output logic              cmd_reject,
  output logic              err_q
);
  function automatic logic code_is_legal(input logic [DATA_W-1:0] v);
    return (v == INIT_CODE) || (v == FLUSH_CODE);
  endfunction

  logic allowed;

  always_comb begin
    allowed    = !cache_en && !flush_busy;
    cmd_take   = cmd_wr && allowed && code_is_legal(wdata);
    cmd_reject = cmd_wr && !cmd_take;
    flush_go   = cmd_take && (wdata == FLUSH_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      init_pulse <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      init_pulse <= cmd_take && (wdata == INIT_CODE);
      if (cmd_take)   cmd_q <= wdata;
      if (cmd_reject) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cc_flush_addr.sv
module cc_flush_addr #(
  parameter int unsigned DATA_W = cc_pkg::CC_DATA_W,
  parameter int unsigned ADDR_W = cc_pkg::CC_ADDR_W,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lo_rd,
  output logic [DATA_W-1:0] hi_rd,
  output logic [ADDR_W-1:0] flush_addr
);
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_wr) lo_q <= wdata;
      if (hi_wr) hi_q <= wdata[HI_W-1:0];
    end
  end

  assign lo_rd      = lo_q;
  assign hi_rd      = {{(DATA_W-HI_W){1'b0}}, hi_q};
  assign flush_addr = {hi_q, lo_q};
endmodule

// File: rtl/cc_flush_fsm.sv
module cc_flush_fsm #(
  parameter int unsigned ADDR_W = cc_pkg::CC_ADDR_W,
  parameter int unsigned OFFS_W = cc_pkg::CC_OFFS_W,
  parameter int unsigned SET_W  = cc_pkg::CC_SET_W,
  localparam int unsigned TAG_W = ADDR_W - OFFS_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_go,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              inv_ack,
  output logic              inv_req,
  output logic [SET_W-1:0]  inv_set,
  output logic [TAG_W-1:0]  inv_tag
);
  import cc_pkg::*;

  function automatic logic [SET_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFFS_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  flush_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FL_IDLE;
      inv_set <= '0;
      inv_tag <= '0;
    end else begin
      unique case (st_q)
        FL_IDLE: if (flush_go) begin
          st_q    <= FL_WAIT;
          inv_set <= addr_set(flush_addr);
          inv_tag <= addr_tag(flush_addr);
        end
        FL_WAIT: if (inv_ack) st_q <= FL_IDLE;
        default: st_q <= FL_IDLE;
      endcase
    end
  end

  assign inv_req = (st_q == FL_WAIT);
endmodule

// File: rtl/cc_miss_ctr.sv
module cc_miss_ctr #(
  parameter int unsigned CNT_W = cc_pkg::CC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_val,
  input  logic             miss_evt,
  output logic [CNT_W-1:0] cnt_q
);
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sw_wr)    cnt_q <= sw_val;
    else if (miss_evt) cnt_q <= cnt_next(cnt_q);
  end
endmodule

// File: rtl/cc_ctrl_regs.sv
module cc_ctrl_regs #(
  parameter int unsigned DATA_W = cc_pkg::CC_DATA_W,
  parameter int unsigned ADDR_W = cc_pkg::CC_ADDR_W,
  parameter int unsigned OFFS_W = cc_pkg::CC_OFFS_W,
  parameter int unsigned SET_W  = cc_pkg::CC_SET_W,
  localparam int unsigned TAG_W = ADDR_W - OFFS_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cache_en,
  input  logic              miss_evt,
  output logic              init_pulse,
  output logic              inv_req,
  output logic [SET_W-1:0]  inv_set,
  output logic [TAG_W-1:0]  inv_tag,
  input  logic              inv_ack,
  output logic              cfg_err
);
  import cc_pkg::*;

  logic              wr_any;
  logic              cmd_wr, lo_wr, hi_wr, ctr_wr;
  logic [DATA_W-1:0] cmd_q, lo_rd, hi_rd, ctr_q;
  logic [ADDR_W-1:0] flush_addr;
  logic              flush_go, cmd_take, cmd_reject;

  always_comb begin
    wr_any = bus_sel && bus_wr;
    cmd_wr = wr_any && (reg_sel_e'(bus_addr) == SEL_CMD);
    lo_wr  = wr_any && (reg_sel_e'(bus_addr) == SEL_FLO);
    hi_wr  = wr_any && (reg_sel_e'(bus_addr) == SEL_FHI);
    ctr_wr = wr_any && (reg_sel_e'(bus_addr) == SEL_MISS);
  end

  cc_cmd_decode #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(bus_wdata),
    .cache_en(cache_en), .flush_busy(inv_req), .cmd_q(cmd_q),
    .init_pulse(init_pulse), .flush_go(flush_go), .cmd_take(cmd_take),
    .cmd_reject(cmd_reject), .err_q(cfg_err)
  );

  cc_flush_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_faddr (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .wdata(bus_wdata), .lo_rd(lo_rd), .hi_rd(hi_rd), .flush_addr(flush_addr)
  );

  cc_flush_fsm #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .SET_W(SET_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .flush_go(flush_go), .flush_addr(flush_addr),
    .inv_ack(inv_ack), .inv_req(inv_req), .inv_set(inv_set), .inv_tag(inv_tag)
  );

  cc_miss_ctr #(.CNT_W(DATA_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .sw_wr(ctr_wr), .sw_val(bus_wdata),
    .miss_evt(miss_evt), .cnt_q(ctr_q)
  );

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      SEL_CMD:  bus_rdata = cmd_q;
      SEL_FLO:  bus_rdata = lo_rd;
      SEL_FHI:  bus_rdata = hi_rd;
      default:  bus_rdata = ctr_q;
    endcase
  end
endmodule

// File: rtl/cc_ctrl_regs_chk.sv
module cc_ctrl_regs_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SET_W  = 8,
  parameter int unsigned TAG_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cache_en,
  input logic              miss_evt,
  input logic              ctr_wr,
  input logic              cmd_reject,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] ctr_q,
  input logic              init_pulse,
  input logic              inv_req,
  input logic              inv_ack,
  input logic [SET_W-1:0]  inv_set,
  input logic [TAG_W-1:0]  inv_tag,
  input logic              cfg_err
);
  a_r3_init_single: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> !init_pulse);
  a_r7_init_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |-> $past(!cache_en));
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_ack) |=> inv_req);
  a_r5_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_ack) |=> !inv_req);
  a_r4_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_ack) |=> ($stable(inv_set) && $stable(inv_tag)));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  a_r6_err_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> cfg_err);
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && !ctr_wr) |=> (ctr_q == DATA_W'($past(ctr_q) + DATA_W'(1))));
  a_r9_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wr |=> (ctr_q == $past(bus_wdata)));
endmodule

bind cc_ctrl_regs cc_ctrl_regs_chk #(.DATA_W(DATA_W), .SET_W(SET_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .miss_evt(miss_evt),
  .ctr_wr(ctr_wr), .cmd_reject(cmd_reject), .bus_wdata(bus_wdata),
  .ctr_q(ctr_q), .init_pulse(init_pulse), .inv_req(inv_req),
  .inv_ack(inv_ack), .inv_set(inv_set), .inv_tag(inv_tag), .cfg_err(cfg_err)
);

// File: tb/test_cc_ctrl_regs.sv
module test_cc_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cache_en = 1'b0, miss_evt = 1'b0, inv_ack = 1'b0;
  logic        init_pulse, inv_req, cfg_err;
  logic [7:0]  inv_set;
  logic [11:0] inv_tag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_ctrl_regs i_cc_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cache_en(cache_en), .miss_evt(miss_evt), .init_pulse(init_pulse),
    .inv_req(inv_req), .inv_set(inv_set), .inv_tag(inv_tag),
    .inv_ack(inv_ack), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cache_en = 1'b0; miss_evt = 1'b0; inv_ack = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // returns at the negedge following the write edge
  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      bus_read(2'(i), d);
      check("R1 reg reset", {16'h0, d}, 32'h0);
    end
    check("R1 inv_req reset", {31'h0, inv_req}, 32'h0);
    check("R1 init_pulse reset", {31'h0, init_pulse}, 32'h0);
    check("R1 cfg_err reset", {31'h0, cfg_err}, 32'h0);
  endtask

  task automatic t_addr_regs();
    logic [15:0] d;
    do_reset();
    bus_write(2'd1, 16'hA55A);
    bus_write(2'd2, 16'hFF34);
    bus_read(2'd1, d); check("R2 low reg", {16'h0, d}, 32'hA55A);
    bus_read(2'd2, d); check("R2 high reg reserved bits", {16'h0, d}, 32'h0034);
  endtask

  task automatic t_init();
    logic [15:0] d;
    do_reset();
    bus_write(2'd0, 16'hCE3C);
    check("R3 init pulse high", {31'h0, init_pulse}, 32'h1);
    check("R3 no flush on init", {31'h0, inv_req}, 32'h0);
    @(negedge clk);
    check("R3 init pulse single", {31'h0, init_pulse}, 32'h0);
    bus_read(2'd0, d); check("R11 cmd readback", {16'h0, d}, 32'hCE3C);
  endtask

  task automatic t_flush();
    logic [15:0] d;
    do_reset();
    bus_write(2'd1, 16'hABC5);
    bus_write(2'd2, 16'h0012);
    bus_write(2'd0, 16'hDE3C);
    check("R4 inv_req raised", {31'h0, inv_req}, 32'h1);
    check("R4 inv_set", {24'h0, inv_set}, 32'hBC);
    check("R4 inv_tag", {20'h0, inv_tag}, 32'h12A);
    bus_write(2'd1, 16'h0000);
    @(negedge clk);
    check("R5 req held", {31'h0, inv_req}, 32'h1);
    check("R5 set held", {24'h0, inv_set}, 32'hBC);
    inv_ack = 1'b1;
    @(negedge clk);
    inv_ack = 1'b0;
    check("R5 req dropped", {31'h0, inv_req}, 32'h0);
    check("R5 no error", {31'h0, cfg_err}, 32'h0);
    bus_read(2'd0, d); check("R11 cmd readback flush", {16'h0, d}, 32'hDE3C);
  endtask

  task automatic t_illegal();
    logic [15:0] d;
    do_reset();
    bus_write(2'd0, 16'hCE3D);
    check("R6 no init", {31'h0, init_pulse}, 32'h0);
    check("R6 no flush", {31'h0, inv_req}, 32'h0);
    check("R6 err set", {31'h0, cfg_err}, 32'h1);
    bus_read(2'd0, d); check("R6 readback unchanged", {16'h0, d}, 32'h0);
    bus_write(2'd0, 16'hCE3C);
    check("R6 err sticky", {31'h0, cfg_err}, 32'h1);
    repeat (3) @(negedge clk);
    check("R6 err still sticky", {31'h0, cfg_err}, 32'h1);
  endtask

  task automatic t_enabled();
    logic [15:0] d;
    do_reset();
    cache_en = 1'b1;
    bus_write(2'd0, 16'hCE3C);
    check("R7 no init when enabled", {31'h0, init_pulse}, 32'h0);
    check("R7 err set", {31'h0, cfg_err}, 32'h1);
    bus_write(2'd0, 16'hDE3C);
    check("R7 no flush when enabled", {31'h0, inv_req}, 32'h0);
    bus_read(2'd0, d); check("R7 readback unchanged", {16'h0, d}, 32'h0);
    cache_en = 1'b0;
  endtask

  task automatic t_busy();
    logic [15:0] d;
    do_reset();
    bus_write(2'd0, 16'hDE3C);
    check("R10 flush pending", {31'h0, inv_req}, 32'h1);
    bus_write(2'd0, 16'hCE3C);
    check("R10 no init while busy", {31'h0, init_pulse}, 32'h0);
    check("R10 err set", {31'h0, cfg_err}, 32'h1);
    bus_read(2'd0, d); check("R10 readback unchanged", {16'h0, d}, 32'hDE3C);
    inv_ack = 1'b1;
    @(negedge clk);
    inv_ack = 1'b0;
    check("R10 request done", {31'h0, inv_req}, 32'h0);
  endtask

  task automatic t_counter();
    logic [15:0] d;
    do_reset();
    @(negedge clk); miss_evt = 1'b1;
    repeat (3) @(negedge clk);
    miss_evt = 1'b0;
    bus_read(2'd3, d); check("R8 count three", {16'h0, d}, 32'h3);
    bus_write(2'd3, 16'hFFFE);
    miss_evt = 1'b1;
    repeat (3) @(negedge clk);
    miss_evt = 1'b0;
    bus_read(2'd3, d); check("R8 wrap", {16'h0, d}, 32'h1);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    do_reset();
    bus_write(2'd3, 16'h00F0);
    @(negedge clk);
    miss_evt = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 16'h1234;
    @(negedge clk);
    miss_evt = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(2'd3, d); check("R9 software write wins", {16'h0, d}, 32'h1234);
  endtask

  initial begin
    t_reset();
    t_addr_regs();
    t_init();
    t_flush();
    t_illegal();
    t_enabled();
    t_busy();
    t_counter();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule